// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is the data and direction core of an eight-pin general purpose I/O port. It sits on a simple register bus. A direction register marks each pin as input or output. A data register holds the values driven on output pins and the sampled levels of input pins. The data register is not reached at one address. It is reached through a 1 KB window of byte offsets, and the word-address bits inside that window select which pins an access may touch. Software can therefore read or change any subset of pins in one bus access, with no read-modify-write sequence and no race against another agent that owns other pins.

External pin levels pass through a two-flop synchronizer. They are then loaded every cycle into the data bits of pins configured as inputs. The block drives a value vector for the pads. An output pin drives its data bit. An input pin drives high, which models a floating line held up by a pull-up. A change vector pulses for one cycle on every pin whose driven value has just moved.

Reset is asynchronous and active-low. Its release passes through a two-stage synchronizer, so the registers leave reset on the second rising edge after the reset input goes high. Bus accesses take effect on the rising edge where `bus_sel` is sampled high. Read data is registered and appears after that edge.

Top module: `gpio_mask_port`

## Requirements
- R1: A byte offset below 0x400 (bits 11:10 zero) selects the data register. Offset bits [9:2] form the pin mask, with bit 2+k selecting pin k. Offset bits [1:0] are ignored.
- R2: A read in the data window returns, in `bus_rdata[7:0]`, the data register ANDed with the pin mask, and returns zeros in bits [31:8]. The value appears just after the clock edge that accepts the read.
- R3: A write in the data window sets data bit k to `bus_wdata[k]` only when mask bit k is 1 and pin k is an output. Every other data bit keeps its value or keeps following its input pin.
- R4: The direction register sits at offset 0x400. Bit k set to 1 makes pin k an output. It reads back zero-extended and resets to 0, so all pins start as inputs.
- R5: For an input pin, the data bit follows `pin_in` through two synchronizer flops. A level that is stable before rising edge E is returned by a read accepted at edge E+3, while a read accepted at edge E+2 still returns the old level. For an output pin, the data bit never follows `pin_in`.
- R6: `pin_out[k]` equals data bit k when pin k is an output, and equals 1 when pin k is an input. After reset `pin_out` is 0xFF.
- R7: `pin_chg[k]` is 1 for exactly the one cycle in which `pin_out[k]` differs from its value in the previous cycle, and is 0 otherwise, including after reset.
- R8: A direction or data write changes `pin_out` right after the edge that accepts it, that is, in the cycle that follows the write cycle.
- R9: The data register resets to 0. An access at any offset outside the data window other than 0x400 reads as 0, and a write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; bits [7:0] are used |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 8 | Asynchronous external pin levels |
| pin_out | output | 8 | Driven pin values |
| pin_chg | output | 8 | One-cycle pulse per pin whose driven value changed |

## Verification
A wrong direction bit shows at `pin_out` in the cycle after the write. The pin is either stuck high or exposes its data bit, and the direction read-back disagrees on the next read. A data register bit that is corrupted, loaded under the wrong mask, or loaded from a pin while that pin is an output shows up in two places. It appears on `pin_out` for output pins at once. It appears in a full-mask read one cycle after the read is issued. A wrong synchronizer depth shifts the cycle in which a new input level first reads back, and the edge-by-edge read sequence pins that cycle down. A stale previous-value register makes `pin_chg` pulse in the wrong cycle, or more than once, which is visible on the very next clock.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // Kind of access decoded from the byte offset
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2,
    ACC_VOID = 2'd3
  } gpio_acc_e;

  localparam int unsigned GPIO_PINS_DEF   = 8;
  localparam int unsigned GPIO_ADDR_DEF   = 12;
  localparam int unsigned GPIO_DATA_DEF   = 32;
  localparam int unsigned GPIO_SYNC_DEF   = 2;
  localparam int unsigned GPIO_DIROFF_DEF = 'h400;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_mask_pkg::*;
#(
  parameter int unsigned ADDR_W     = GPIO_ADDR_DEF,
  parameter int unsigned PIN_W      = GPIO_PINS_DEF,
  parameter int unsigned DIR_OFFSET = GPIO_DIROFF_DEF
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output gpio_acc_e         acc_kind,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic [PIN_W-1:0]  pin_mask
);
  localparam int unsigned       WIN_TOP  = PIN_W + 2;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

  logic in_window;
  logic at_dir;
  logic unused_low;

  assign unused_low = ^bus_addr[1:0];
  assign in_window  = (bus_addr[ADDR_W-1:WIN_TOP] == '0);
  assign at_dir     = (bus_addr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2]);
  assign pin_mask   = bus_addr[WIN_TOP-1:2];

  always_comb begin
    if (!bus_sel)       acc_kind = ACC_IDLE;
    else if (in_window) acc_kind = ACC_DATA;
    else if (at_dir)    acc_kind = ACC_DIR;
    else                acc_kind = ACC_VOID;
  end

  assign acc_wr = bus_sel &  bus_wr;
  assign acc_rd = bus_sel & ~bus_wr;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] pin_raw,
  output logic [PIN_W-1:0] pin_sync
);
  logic [PIN_W-1:0] stage_q [STAGES];
  logic [PIN_W-1:0] stage_d [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = pin_raw;
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs #(
  parameter int unsigned PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic [PIN_W-1:0] dir_wdata,
  input  logic             data_we,
  input  logic [PIN_W-1:0] data_wmask,
  input  logic [PIN_W-1:0] data_wdata,
  input  logic [PIN_W-1:0] pin_sync,
  output logic [PIN_W-1:0] dir_q,
  output logic [PIN_W-1:0] data_q
);
  logic [PIN_W-1:0] dir_d;
  logic [PIN_W-1:0] data_d;
  logic [PIN_W-1:0] wr_bits;
  logic [PIN_W-1:0] held_out;

  // Direction register: whole-byte load on its own offset
  always_comb begin
    dir_d = dir_q;
    if (dir_we) dir_d = dir_wdata;
  end

  // Data register: output bits take masked writes, input bits track pins
  always_comb begin
    wr_bits  = data_we ? (data_wmask & dir_q) : '0;
    held_out = (data_q & ~wr_bits) | (data_wdata & wr_bits);
    data_d   = (held_out & dir_q) | (pin_sync & ~dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      dir_q  <= dir_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/gpio_out_drive.sv
module gpio_out_drive #(
  parameter int unsigned PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_W-1:0] dir_q,
  input  logic [PIN_W-1:0] data_q,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_chg
);
  logic [PIN_W-1:0] drive_now;
  logic [PIN_W-1:0] prev_q;
  logic [PIN_W-1:0] prev_d;

  genvar k;
  generate
    for (k = 0; k < PIN_W; k++) begin : g_pin
      assign drive_now[k] = dir_q[k] ? data_q[k] : 1'b1;
      assign pin_chg[k]   = drive_now[k] ^ prev_q[k];
    end
  endgenerate

  always_comb begin
    prev_d = drive_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= prev_d;
  end

  assign pin_out = drive_now;
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PIN_W      = GPIO_PINS_DEF,
  parameter int unsigned ADDR_W     = GPIO_ADDR_DEF,
  parameter int unsigned DATA_W     = GPIO_DATA_DEF,
  parameter int unsigned SYNC_N     = GPIO_SYNC_DEF,
  parameter int unsigned DIR_OFFSET = GPIO_DIROFF_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_chg
);
  logic              rst_sync_n;
  gpio_acc_e         acc_kind;
  logic              acc_wr;
  logic              acc_rd;
  logic [PIN_W-1:0]  pin_mask;
  logic [PIN_W-1:0]  pin_sync;
  logic [PIN_W-1:0]  dir_q;
  logic [PIN_W-1:0]  data_q;
  logic              dir_we;
  logic              data_we;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rd_value;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:PIN_W];

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_bus_decode #(
    .ADDR_W     (ADDR_W),
    .PIN_W      (PIN_W),
    .DIR_OFFSET (DIR_OFFSET)
  ) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .acc_kind (acc_kind),
    .acc_wr   (acc_wr),
    .acc_rd   (acc_rd),
    .pin_mask (pin_mask)
  );

  gpio_in_sync #(.PIN_W(PIN_W), .STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pin_raw  (pin_in),
    .pin_sync (pin_sync)
  );

  assign dir_we  = acc_wr && (acc_kind == ACC_DIR);
  assign data_we = acc_wr && (acc_kind == ACC_DATA);

  gpio_pin_regs #(.PIN_W(PIN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .dir_we     (dir_we),
    .dir_wdata  (bus_wdata[PIN_W-1:0]),
    .data_we    (data_we),
    .data_wmask (pin_mask),
    .data_wdata (bus_wdata[PIN_W-1:0]),
    .pin_sync   (pin_sync),
    .dir_q      (dir_q),
    .data_q     (data_q)
  );

  gpio_out_drive #(.PIN_W(PIN_W)) u_drive (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dir_q   (dir_q),
    .data_q  (data_q),
    .pin_out (pin_out),
    .pin_chg (pin_chg)
  );

  // Read path: select, then register on an accepted read only
  always_comb begin
    case (acc_kind)
      ACC_DATA: rd_value = DATA_W'(data_q & pin_mask);
      ACC_DIR:  rd_value = DATA_W'(dir_q);
      default:  rd_value = '0;
    endcase
    rdata_d = acc_rd ? rd_value : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int unsigned PIN_W      = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DIR_OFFSET = 'h400
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_chg,
  input logic [PIN_W-1:0]  dir_q
);
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFFSET);

  logic             c_win;
  logic             c_dir;
  logic [PIN_W-1:0] c_mask;
  logic [PIN_W-1:0] c_wbyte;
  logic             unused_chk;

  assign unused_chk = ^{bus_wdata[DATA_W-1:PIN_W], bus_addr[1:0]};
  assign c_win   = (bus_addr[ADDR_W-1:PIN_W+2] == '0);
  assign c_dir   = (bus_addr[ADDR_W-1:2] == DIR_ADDR[ADDR_W-1:2]);
  assign c_mask  = bus_addr[PIN_W+1:2];
  assign c_wbyte = bus_wdata[PIN_W-1:0];

  AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(bus_sel && !bus_wr && c_win) |-> ((bus_rdata[PIN_W-1:0] & ~$past(c_mask)) == '0) && (bus_rdata[DATA_W-1:PIN_W] == '0)); // R2
  AST_WRITE_APPLIED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(bus_sel && bus_wr && c_win) |-> (((pin_out ^ $past(c_wbyte)) & $past(c_mask & dir_q)) == '0)); // R3
  AST_WRITE_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(bus_sel && bus_wr && c_win) |-> (((pin_out ^ $past(pin_out)) & $past(dir_q & ~c_mask)) == '0)); // R3
  AST_INPUT_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(bus_sel && bus_wr && c_dir && !c_win) |-> ((~$past(c_wbyte) & ~pin_out) == '0)); // R8
  AST_PINS_IGNORED_ON_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(bus_sel && bus_wr) |-> (pin_out == $past(pin_out))); // R5
  AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pin_chg == (pin_out ^ $past(pin_out))); // R7
  AST_VOID_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(bus_sel && !bus_wr && !c_win && !c_dir) |-> (bus_rdata == '0)); // R9
endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .PIN_W      (PIN_W),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .DIR_OFFSET (DIR_OFFSET)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_out    (pin_out),
  .pin_chg    (pin_chg),
  .dir_q      (dir_q)
);

// File: tb/gpio_mask_port_tb_top.sv
module gpio_mask_port_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_chg;

  int n_vec;
  int n_bad;
  bit done;

  gpio_mask_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_chg(pin_chg)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Row: op[41:40] (0 write, 1 read), addr[39:28], wdata[27:20],
  //      expected read[19:12], expected pin_out[11:4], requirement[3:0]
  // pin_in is held at 0xA5 throughout the table.
  localparam int NV = 20;
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 12'h400, 8'h0F, 8'h00, 8'hF5, 4'd4},  // R4 low nibble to outputs
    {2'd1, 12'h400, 8'h00, 8'h0F, 8'hF5, 4'd4},  // R4 read back
    {2'd0, 12'h3FC, 8'h3C, 8'h00, 8'hFC, 4'd3},  // R3 full mask, outputs only
    {2'd1, 12'h3FC, 8'h00, 8'hAC, 8'hFC, 4'd2},  // R2 full mask read
    {2'd1, 12'h03C, 8'h00, 8'h0C, 8'hFC, 4'd1},  // R1 mask 0x0F
    {2'd1, 12'h200, 8'h00, 8'h80, 8'hFC, 4'd1},  // R1 mask 0x80
    {2'd0, 12'h00C, 8'hFF, 8'h00, 8'hFF, 4'd3},  // R3 mask 0x03
    {2'd1, 12'h3FF, 8'h00, 8'hAF, 8'hFF, 4'd1},  // R1 low bits ignored
    {2'd0, 12'h3C0, 8'h00, 8'h00, 8'hFF, 4'd3},  // R3 mask on inputs only
    {2'd1, 12'h3FC, 8'h00, 8'hAF, 8'hFF, 4'd3},
    {2'd0, 12'h000, 8'h00, 8'h00, 8'hFF, 4'd3},  // R3 empty mask
    {2'd1, 12'h3FC, 8'h00, 8'hAF, 8'hFF, 4'd3},
    {2'd0, 12'h404, 8'hFF, 8'h00, 8'hFF, 4'd9},  // R9 void write
    {2'd1, 12'h404, 8'h00, 8'h00, 8'hFF, 4'd9},  // R9 void read
    {2'd1, 12'h400, 8'h00, 8'h0F, 8'hFF, 4'd9},
    {2'd0, 12'h400, 8'hF0, 8'h00, 8'hAF, 4'd6},  // R6 swap directions
    {2'd1, 12'h400, 8'h00, 8'hF0, 8'hAF, 4'd4},
    {2'd1, 12'h3FC, 8'h00, 8'hA5, 8'hAF, 4'd5},  // R5 low nibble now from pins
    {2'd0, 12'h3C0, 8'h5A, 8'h00, 8'h5F, 4'd3},  // R3 high nibble written
    {2'd1, 12'h3FC, 8'h00, 8'h55, 8'h5F, 4'd2}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = {24'hDEAD_BE, d};
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic do_reset(input logic [7:0] pins);
    @(negedge clk);
    rst_n = 1'b0; pin_in = pins; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;

    // Reset state
    do_reset(8'h00);
    check("R6", "pin_out after reset", 32'(pin_out), 32'hFF);
    check("R7", "pin_chg after reset", 32'(pin_chg), 32'h00);
    bus_read(12'h400);
    check("R4", "direction after reset", bus_rdata, 32'h0);
    bus_read(12'h3FC);
    check("R9", "data after reset", bus_rdata, 32'h0);

    // R5 synchronizer latency: hold a full-mask read every cycle
    @(negedge clk);
    pin_in = 8'h3C; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h3FC;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R5", $sformatf("input read edge %0d", k), bus_rdata, (k == 3) ? 32'h3C : 32'h0);
    end
    bus_sel = 1'b0;

    // R8 / R7 direction timing and change pulse
    check("R8", "pin_out before dir write", 32'(pin_out), 32'hFF);
    bus_write(12'h400, 8'h01);
    check("R8", "pin_out after dir write", 32'(pin_out), 32'hFE);
    check("R7", "pulse on dir change", 32'(pin_chg), 32'h01);
    @(negedge clk);
    check("R7", "pulse lasts one cycle", 32'(pin_chg), 32'h00);
    bus_write(12'h004, 8'h01);
    check("R8", "pin_out after data write", 32'(pin_out), 32'hFF);
    check("R7", "pulse on data write", 32'(pin_chg), 32'h01);

    // R5 output pin ignores pin activity; inputs give no pulse
    @(negedge clk);
    pin_in = 8'h00;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R7", "no pulse from input pins", 32'(pin_chg), 32'h00);
    end
    check("R5", "output pin held", 32'(pin_out), 32'hFF);
    bus_read(12'h3FC);
    check("R5", "output data not from pin", bus_rdata, 32'h01);

    // R9 far void offset
    bus_write(12'h800, 8'hFF);
    bus_read(12'h800);
    check("R9", "void read", bus_rdata, 32'h0);
    bus_read(12'h400);
    check("R9", "dir untouched by void write", bus_rdata, 32'h01);

    // Vector table
    do_reset(8'hA5);
    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VEC[i];
      if (v[41:40] == 2'd0) bus_write(v[39:28], v[27:20]);
      else begin
        bus_read(v[39:28]);
        check($sformatf("R%0d", v[3:0]), $sformatf("row %0d rdata", i), bus_rdata, 32'(v[19:12]));
      end
      check($sformatf("R%0d", v[3:0]), $sformatf("row %0d pin_out", i), 32'(pin_out), 32'(v[11:4]));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule